// File: doc/BRIEF.md
# Edge-Timing Lock Detector with Output Muting

This block decides whether a frequency synthesizer's loop has settled. It receives one-cycle pulses marking reference edges and feedback edges, both already in the domain of a fast sample clock. For each reference cycle it counts sample-clock ticks from whichever edge arrives first to the edge that follows it. If that count is below a threshold, the cycle counts as good. The block raises its lock flag once enough good cycles have come in a row. A precision input sets how many are needed: three or five.

The block also drives the RF output enable. When muting is selected, the enable stays low until lock is reached. When muting is off, the enable depends only on the power-down input. Power-down acts as a synchronous clear of all measurement state and of the lock flag. It also forces the output enable low at once.

Top module: `lock_detect_mute`

## Requirements
- R1: While `pd` is high, or after reset, `lock_det` is 0 and the good-cycle count is empty. After `pd` falls, a full new run of good cycles is needed before lock.
- R2: The error of a cycle is the number of clock edges from the first edge pulse to the matching pulse of the other kind. The cycle is good only if this count is below `THRESH_TICKS`. With the default of 3, a gap of 2 is good and a gap of 3 is bad. Pulses in the same cycle give an error of 0.
- R3: With `prec_sel` = 1, `lock_det` rises only after five consecutive good cycles.
- R4: With `prec_sel` = 0, `lock_det` rises only after three consecutive good cycles.
- R5: A bad cycle empties the good-cycle count and drops `lock_det`.
- R6: A reference pulse that arrives while the previous reference still waits for its feedback counts as a bad cycle. That pulse then starts a new measurement.
- R7: When the feedback pulse leads, the measurement runs from the feedback pulse to the next reference pulse, with the same threshold.
- R8: With `mute_en` = 1, `out_en` = 1 only while `lock_det` = 1 and `pd` = 0.
- R9: With `mute_en` = 0, `out_en` is the inverse of `pd`, whatever the lock state.
- R10: `lock_det` changes at the clock edge that samples the pulse completing the deciding cycle. It is visible just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; ticks measure phase error |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd | input | 1 | Power-down; synchronous clear, forces output off |
| ref_pulse | input | 1 | One-cycle pulse on each reference edge |
| fb_pulse | input | 1 | One-cycle pulse on each feedback edge |
| prec_sel | input | 1 | 1: five good cycles for lock, 0: three |
| mute_en | input | 1 | 1: hold output off until lock |
| lock_det | output | 1 | Lock indication |
| out_en | output | 1 | RF output enable |

## Verification
The bench uses the default parameters. A threshold of 3 ticks at a 5 ns clock matches the 15 ns limit, and the gap between a good cycle (2 ticks) and a bad one (3 ticks) is one tick, so the threshold can be tested on both sides. Good-cycle counts of three and five keep both lock lengths short. This lets one run cover switching precision, a missing feedback edge, cycles where the feedback leads, edges in the same cycle, and power-down while locked.

// File: rtl/lock_detect_mute.sv
module lock_detect_mute #(
  parameter int THRESH_TICKS = 3,
  parameter int FEW_CYCLES   = 3,
  parameter int MANY_CYCLES  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic prec_sel,
  input  logic mute_en,
  output logic lock_det,
  output logic out_en
);
  localparam int CW = $clog2(THRESH_TICKS + 1);
  localparam int GW = $clog2(MANY_CYCLES + 1);

  typedef enum logic [1:0] {IDLE, REF_LEAD, FB_LEAD} meas_t;

  meas_t          st, st_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic [GW-1:0]  gcnt, gnext, need;
  logic           ev, good, lock_q;

  assign need = prec_sel ? GW'(MANY_CYCLES) : GW'(FEW_CYCLES);

  always_comb begin
    ev    = 1'b0;
    good  = 1'b0;
    st_n  = st;
    cnt_n = (cnt == CW'(THRESH_TICKS)) ? cnt : cnt + CW'(1);
    case (st)
      IDLE: begin
        if (ref_pulse && fb_pulse) begin
          ev = 1'b1; good = 1'b1;
        end else if (ref_pulse) begin
          st_n = REF_LEAD; cnt_n = CW'(1);
        end else if (fb_pulse) begin
          st_n = FB_LEAD; cnt_n = CW'(1);
        end
      end
      REF_LEAD: begin
        if (fb_pulse) begin
          ev = 1'b1; good = cnt < CW'(THRESH_TICKS);
          if (ref_pulse) cnt_n = CW'(1);
          else st_n = IDLE;
        end else if (ref_pulse) begin
          ev = 1'b1; cnt_n = CW'(1);
        end
      end
      FB_LEAD: begin
        if (ref_pulse) begin
          ev = 1'b1; good = cnt < CW'(THRESH_TICKS);
          if (fb_pulse) cnt_n = CW'(1);
          else st_n = IDLE;
        end else if (fb_pulse) begin
          ev = 1'b1; cnt_n = CW'(1);
        end
      end
      default: st_n = IDLE;
    endcase
  end

  assign gnext = !good ? '0 : (gcnt == GW'(MANY_CYCLES)) ? gcnt : gcnt + GW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; gcnt <= '0; lock_q <= 1'b0;
    end else if (pd) begin
      st <= IDLE; cnt <= '0; gcnt <= '0; lock_q <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      if (ev) begin
        gcnt   <= gnext;
        lock_q <= good && (gnext >= need);
      end
    end
  end

  assign lock_det = lock_q;
  assign out_en   = !pd && (!mute_en || lock_q);

  assert_pd_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !lock_det);
  assert_bad_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !good && !pd) |=> (!lock_det && gcnt == '0));
  assert_rise_on_good_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_det) |-> $past(ev && good));
  assert_gcnt_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt <= GW'(MANY_CYCLES));
endmodule

// File: tb/lock_detect_mute_bench.sv
`timescale 1ns/1ps
module lock_detect_mute_bench;
  localparam int TH = 3;
  logic clk = 1'b0, rst_n = 1'b0, pd = 1'b0;
  logic ref_i = 1'b0, fb_i = 1'b0, prec = 1'b0, mute = 1'b1;
  logic lock_det, out_en;
  int errors = 0, checks = 0;
  int st = 0, t0 = 0, cyc = 0, g = 0;
  bit lk = 1'b0;

  always #2.5 clk = ~clk;

  lock_detect_mute u_lock_detect_mute (
    .clk(clk), .rst_n(rst_n), .pd(pd), .ref_pulse(ref_i), .fb_pulse(fb_i),
    .prec_sel(prec), .mute_en(mute), .lock_det(lock_det), .out_en(out_en));

  task automatic model_edge();
    bit ev = 0, good = 0;
    int need = prec ? 5 : 3;
    if (!rst_n || pd) begin
      st = 0; g = 0; lk = 0;
    end else begin
      case (st)
        0: if (ref_i && fb_i) begin ev = 1; good = 1; end
           else if (ref_i) begin st = 1; t0 = cyc; end
           else if (fb_i) begin st = 2; t0 = cyc; end
        1: if (fb_i) begin ev = 1; good = (cyc - t0) < TH;
             if (ref_i) t0 = cyc; else st = 0; end
           else if (ref_i) begin ev = 1; t0 = cyc; end
        default: if (ref_i) begin ev = 1; good = (cyc - t0) < TH;
             if (fb_i) t0 = cyc; else st = 0; end
           else if (fb_i) begin ev = 1; t0 = cyc; end
      endcase
      if (ev) begin
        g = good ? ((g < 5) ? g + 1 : 5) : 0;
        lk = good && (g >= need);
      end
    end
    cyc++;
  endtask

  task automatic check(string tag);
    bit exp_en = !pd && (!mute || lk);
    checks++;
    if (lock_det !== lk || out_en !== exp_en) begin
      errors++;
      $display("FAIL %s: lock_det=%0b out_en=%0b expected lock_det=%0b out_en=%0b",
               tag, lock_det, out_en, lk, exp_en);
    end
  endtask

  task automatic step(bit r, bit f, string tag);
    @(negedge clk);
    ref_i = r; fb_i = f;
    @(posedge clk);
    model_edge();
    #1 check(tag);
  endtask

  task automatic period(int offset, bit fb_first, string tag);
    for (int i = 0; i < 8; i++)
      step(fb_first ? (i == offset) : (i == 0), fb_first ? (i == 0) : (i == offset), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    prec = 0; mute = 1;
    for (int k = 0; k < 4; k++) period(1, 0, "R4 R8 R10 three to lock");
    period(3, 0, "R2 R5 gap at threshold is bad");
    for (int k = 0; k < 3; k++) period(2, 0, "R2 R4 gap below threshold");
    prec = 1;
    period(9, 0, "R6 missing feedback");
    for (int k = 0; k < 6; k++) period(1, 0, "R3 five to lock");
    for (int k = 0; k < 3; k++) period(2, 1, "R7 feedback leads");
    period(3, 1, "R7 R5 feedback leads too far");
    for (int k = 0; k < 6; k++) period(0, 0, "R2 same-cycle edges");
    @(negedge clk) pd = 1;
    step(0, 0, "R1 power-down clears");
    period(1, 0, "R1 pulses ignored in power-down");
    @(negedge clk) pd = 0;
    prec = 0;
    for (int k = 0; k < 2; k++) period(1, 0, "R1 relock needs full run");
    mute = 0;
    period(3, 0, "R9 unmuted while unlocked");
    @(negedge clk) pd = 1;
    step(0, 0, "R9 unmuted power-down");
    @(negedge clk) pd = 0;
    step(0, 0, "R9 unmuted after power-down");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule